// File: doc/BRIEF.md
# Frame Fetch Setup Sequencer

This block prepares each frame fetch of a display controller before any pixel moves. On a start pulse it checks that the framebuffer addresses in use are valid. It then reads the format field from the first word of the palette header and decodes the pixel depth. It works out where pixel data begins and confirms that the configured resolution fits inside the current buffer. If the frame is usable, it posts the DMA condition for the buffer it used and, in double-buffer mode, swaps to the other buffer.

The results stay on the outputs until the next setup: the start address of the first line, the line stride, the bits per pixel, the line range taken from the subpanel setting, and the 16-bit path choice. Setup ends with a one-cycle done pulse. Every status strobe of that setup is high in the same cycle as done. The pixel transfer itself is handled elsewhere.

Top module: `frame_setup_seq`

## Requirements
- R1: A start pulse while `ctrl_en` is low, or while `pal_mode` is 1, produces a done pulse and nothing else. No header read, no strobe, no output update and no buffer swap take place.
- R2: The 3-bit header format field (bits 14:12 of the first palette word) sets the depth: 1 gives 2 bpp, 2 gives 4 bpp, 3 gives 8 bpp, and 4 to 7 give 16 bpp. `tft16` is high when the depth is 16 and `tft` is high. When it is low, the 12-bit path is meant.
- R3: With `pal_mode` other than 2, the header is read at the top address of the current buffer. Pixel data then begins 0x200 bytes past the top for format field 3 to 7, and 0x20 bytes past it for 1 and 2. With `pal_mode` 2 no header is read, the offset is 0, and the format captured last is used (0 after reset).
- R4: If offset + width*height*bpp/8 exceeds (bottom - top) + 2 of the current buffer, `sync_err` and `en_clear` pulse and no DMA condition bit is set. A sum of exactly (bottom - top) + 2 still fits.
- R5: A successful setup pulses `dma_cond_set` bit 0 for buffer 0 or bit 1 for buffer 1, the buffer it used. It also pulses `dma_irq` when `dma_ie[0]` is set.
- R6: `cur_frame` starts at 0. It toggles after each successful setup when `dual` is high, holds when `dual` is low, and returns to 0 while `ctrl_en` is low.
- R7: If the top or bottom valid flag of buffer 0 (`addr_ok[0]`, `addr_ok[1]`) is low, the setup stops without reading the header. The same applies to the flags of buffer 1 (`addr_ok[2]`, `addr_ok[3]`), but only when `dual` is high. A stopped setup pulses `addr_err`, `en_clear` and `dma_cond_set` bit 2, and pulses `dma_irq` when `dma_ie[1]` is set.
- R8: With `sp_on` low, lines run from 0 up to `height`. With `sp_on` and `sp_from_top` high, they run from `sp_lines` up to `height`. With `sp_on` high and `sp_from_top` low, they run from 0 up to `sp_lines`.
- R9: `stride` is width*bpp/8 rounded down. `line_addr` is top + offset + stride*`line_first`, modulo 2^AW.
- R10: A format field of 0 ends the setup with a `skip` pulse. No DMA condition bit is set, and no buffer swap takes place.
- R11: `done` lasts one cycle, and every status strobe is high only in that cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Start of frame setup pulse |
| ctrl_en | input | 1 | Controller enabled |
| pal_mode | input | 2 | Palette mode (1: no setup, 2: no header) |
| tft | input | 1 | Active-matrix panel select |
| dual | input | 1 | Double-buffer mode |
| dma_ie | input | 2 | DMA interrupt enables (0: frame, 1: address) |
| width | input | DIM_W | Pixels per line |
| height | input | DIM_W | Lines per frame |
| sp_on | input | 1 | Subpanel enable |
| sp_from_top | input | 1 | Subpanel value is the first line |
| sp_lines | input | LINE_W | Subpanel line value |
| f0_top | input | AW | Buffer 0 top address |
| f0_bot | input | AW | Buffer 0 bottom address |
| f1_top | input | AW | Buffer 1 top address |
| f1_bot | input | AW | Buffer 1 bottom address |
| addr_ok | input | 4 | Valid flags: f0 top, f0 bottom, f1 top, f1 bottom |
| hdr_req | output | 1 | Header read request |
| hdr_addr | output | AW | Header read address |
| hdr_vld | input | 1 | Header data valid |
| hdr_fmt | input | 3 | Format field of the first header word |
| done | output | 1 | Setup finished |
| skip | output | 1 | Unsupported format strobe |
| sync_err | output | 1 | Frame overflow strobe |
| addr_err | output | 1 | Invalid address strobe |
| en_clear | output | 1 | Request to clear the enable |
| dma_cond_set | output | 3 | DMA condition bit set strobes |
| dma_irq | output | 1 | DMA interrupt strobe |
| cur_frame | output | 1 | Current buffer index |
| bpp | output | 5 | Bits per pixel |
| tft16 | output | 1 | 16-bit path selected |
| stride | output | DIM_W+2 | Line stride in bytes |
| line_first | output | DIM_W | First line drawn |
| line_end | output | DIM_W | Line after the last drawn |
| line_addr | output | AW | Address of the first drawn line |

## Verification
Some rules are checked by assertions on every cycle. Every strobe must coincide with done, and done must last one cycle. An overflow must clear the enable and set no condition bit. An address failure must set only condition bit 2. A success must set exactly one buffer bit. The buffer index must flip on each swap and return to 0 while the controller is disabled.

Other behaviour can only be shown by the bench scenarios:
- the depth and offset decoding;
- the exact fit boundary at size + 2;
- buffer 1 flags being ignored outside double-buffer mode;
- the reuse of the stored format in headerless mode;
- the subpanel line ranges;
- the stride and line address values.

// File: rtl/fs_pkg.sv
package fs_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_HDR,
    ST_CHECK,
    ST_ISSUE,
    ST_DONE
  } fs_state_e;

  localparam int OFF_W = 10;
  localparam int BPP_W = 5;
  localparam logic [OFF_W-1:0] HDR_LONG  = 10'h200;
  localparam logic [OFF_W-1:0] HDR_SHORT = 10'h020;
endpackage

// File: rtl/fs_fmt_decode.sv
module fs_fmt_decode
  import fs_pkg::*;
(
  input  logic [2:0]       fmt,
  input  logic [1:0]       pal_mode,
  input  logic             tft,
  output logic [BPP_W-1:0] bpp,
  output logic [OFF_W-1:0] data_off,
  output logic             supported,
  output logic             tft16
);
  always_comb begin
    case (fmt)
      3'd0:    bpp = 5'd0;
      3'd1:    bpp = 5'd2;
      3'd2:    bpp = 5'd4;
      3'd3:    bpp = 5'd8;
      default: bpp = 5'd16;
    endcase
  end

  assign supported = (fmt != 3'd0);
  assign tft16     = fmt[2] & tft;

  always_comb begin
    if (pal_mode == 2'd2) data_off = '0;
    else if (fmt >= 3'd3) data_off = HDR_LONG;
    else                  data_off = HDR_SHORT;
  end
endmodule

// File: rtl/fs_geom.sv
module fs_geom
  import fs_pkg::*;
#(
  parameter int AW     = 32,
  parameter int DIM_W  = 11,
  parameter int LINE_W = 10
) (
  input  logic [DIM_W-1:0]  width,
  input  logic [DIM_W-1:0]  height,
  input  logic [BPP_W-1:0]  bpp,
  input  logic [OFF_W-1:0]  data_off,
  input  logic [AW-1:0]     top,
  input  logic [AW-1:0]     bot,
  input  logic              sp_on,
  input  logic              sp_from_top,
  input  logic [LINE_W-1:0] sp_lines,
  output logic              fits,
  output logic [DIM_W+1:0]  stride,
  output logic [DIM_W-1:0]  first_line,
  output logic [DIM_W-1:0]  end_line,
  output logic [AW-1:0]     line_addr
);
  localparam int PW = 2 * DIM_W + BPP_W;
  localparam int SW = DIM_W + 2;
  localparam int CW = ((AW > PW) ? AW : PW) + 2;

  logic [PW-1:0] w_x, h_x, b_x, bytes;
  logic [CW-1:0] need_end, room_end;

  assign w_x   = PW'(width);
  assign h_x   = PW'(height);
  assign b_x   = PW'(bpp);
  assign bytes = (w_x * h_x * b_x) >> 3;

  assign need_end = CW'(data_off) + CW'(bytes) + CW'(top);
  assign room_end = CW'(bot) + CW'(2);
  assign fits     = (need_end <= room_end);

  assign stride = SW'((w_x * b_x) >> 3);

  always_comb begin
    first_line = '0;
    end_line   = height;
    if (sp_on) begin
      if (sp_from_top) first_line = DIM_W'(sp_lines);
      else             end_line   = DIM_W'(sp_lines);
    end
  end

  assign line_addr = top + AW'(data_off) + AW'(stride) * AW'(first_line);
endmodule

// File: rtl/fs_frame_sel.sv
module fs_frame_sel #(
  parameter int AW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          ctrl_en,
  input  logic          dual,
  input  logic          toggle,
  input  logic [AW-1:0] f0_top,
  input  logic [AW-1:0] f0_bot,
  input  logic [AW-1:0] f1_top,
  input  logic [AW-1:0] f1_bot,
  input  logic [3:0]    addr_ok,
  output logic          cur,
  output logic [AW-1:0] sel_top,
  output logic [AW-1:0] sel_bot,
  output logic          addrs_ok
);
  logic [1:0] frame_ok, frame_used;
  logic       cur_q, cur_d;

  for (genvar f = 0; f < 2; f++) begin : g_frame
    assign frame_ok[f] = addr_ok[2*f] & addr_ok[2*f+1];
    if (f == 0) begin : g_primary
      assign frame_used[f] = 1'b1;
    end else begin : g_second
      assign frame_used[f] = dual;
    end
  end

  assign addrs_ok = &(frame_ok | ~frame_used);

  always_comb begin
    cur_d = cur_q;
    if (!ctrl_en)    cur_d = 1'b0;
    else if (toggle) cur_d = ~cur_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cur_q <= 1'b0;
    else        cur_q <= cur_d;
  end

  assign cur     = cur_q;
  assign sel_top = cur_q ? f1_top : f0_top;
  assign sel_bot = cur_q ? f1_bot : f0_bot;

  assert_swap_flips_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (toggle && ctrl_en) |=> (cur != $past(cur)));
  assert_idle_zero_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !ctrl_en |=> !cur);
endmodule

// File: rtl/frame_setup_seq.sv
module frame_setup_seq
  import fs_pkg::*;
#(
  parameter int AW     = 32,
  parameter int DIM_W  = 11,
  parameter int LINE_W = 10
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic              ctrl_en,
  input  logic [1:0]        pal_mode,
  input  logic              tft,
  input  logic              dual,
  input  logic [1:0]        dma_ie,
  input  logic [DIM_W-1:0]  width,
  input  logic [DIM_W-1:0]  height,
  input  logic              sp_on,
  input  logic              sp_from_top,
  input  logic [LINE_W-1:0] sp_lines,
  input  logic [AW-1:0]     f0_top,
  input  logic [AW-1:0]     f0_bot,
  input  logic [AW-1:0]     f1_top,
  input  logic [AW-1:0]     f1_bot,
  input  logic [3:0]        addr_ok,
  output logic              hdr_req,
  output logic [AW-1:0]     hdr_addr,
  input  logic              hdr_vld,
  input  logic [2:0]        hdr_fmt,
  output logic              done,
  output logic              skip,
  output logic              sync_err,
  output logic              addr_err,
  output logic              en_clear,
  output logic [2:0]        dma_cond_set,
  output logic              dma_irq,
  output logic              cur_frame,
  output logic [4:0]        bpp,
  output logic              tft16,
  output logic [DIM_W+1:0]  stride,
  output logic [DIM_W-1:0]  line_first,
  output logic [DIM_W-1:0]  line_end,
  output logic [AW-1:0]     line_addr
);
  fs_state_e st_q, st_d;
  logic [2:0] fmt_q, fmt_d;
  logic skip_d, sync_d, aerr_d, enc_d, irq_d, toggle, out_ld;
  logic skip_q, sync_q, aerr_q, enc_q, irq_q;
  logic [2:0] cond_d, cond_q;

  logic             cur, addrs_ok;
  logic [AW-1:0]    sel_top, sel_bot;
  logic [BPP_W-1:0] dec_bpp;
  logic [OFF_W-1:0] dec_off;
  logic             dec_ok, dec_tft16, fits;
  logic [DIM_W+1:0] g_stride;
  logic [DIM_W-1:0] g_first, g_end;
  logic [AW-1:0]    g_addr;

  logic [BPP_W-1:0] bpp_q;
  logic             tft16_q;
  logic [DIM_W+1:0] stride_q;
  logic [DIM_W-1:0] first_q, end_q;
  logic [AW-1:0]    addr_q;

  fs_frame_sel #(.AW(AW)) u_sel (
    .clk(clk), .rst_n(rst_n), .ctrl_en(ctrl_en), .dual(dual),
    .toggle(toggle), .f0_top(f0_top), .f0_bot(f0_bot), .f1_top(f1_top),
    .f1_bot(f1_bot), .addr_ok(addr_ok), .cur(cur), .sel_top(sel_top),
    .sel_bot(sel_bot), .addrs_ok(addrs_ok)
  );

  fs_fmt_decode u_dec (
    .fmt(fmt_q), .pal_mode(pal_mode), .tft(tft), .bpp(dec_bpp),
    .data_off(dec_off), .supported(dec_ok), .tft16(dec_tft16)
  );

  fs_geom #(.AW(AW), .DIM_W(DIM_W), .LINE_W(LINE_W)) u_geom (
    .width(width), .height(height), .bpp(dec_bpp), .data_off(dec_off),
    .top(sel_top), .bot(sel_bot), .sp_on(sp_on), .sp_from_top(sp_from_top),
    .sp_lines(sp_lines), .fits(fits), .stride(g_stride),
    .first_line(g_first), .end_line(g_end), .line_addr(g_addr)
  );

  always_comb begin
    st_d   = st_q;
    fmt_d  = fmt_q;
    skip_d = 1'b0;
    sync_d = 1'b0;
    aerr_d = 1'b0;
    enc_d  = 1'b0;
    irq_d  = 1'b0;
    cond_d = 3'b000;
    toggle = 1'b0;
    out_ld = 1'b0;
    case (st_q)
      ST_IDLE: begin
        if (start) begin
          if (!ctrl_en || pal_mode == 2'd1) begin
            st_d = ST_DONE;
          end else if (!addrs_ok) begin
            st_d   = ST_DONE;
            aerr_d = 1'b1;
            enc_d  = 1'b1;
            cond_d = 3'b100;
            irq_d  = dma_ie[1];
          end else if (pal_mode == 2'd2) begin
            st_d = ST_CHECK;
          end else begin
            st_d = ST_HDR;
          end
        end
      end
      ST_HDR: begin
        if (hdr_vld) begin
          fmt_d = hdr_fmt;
          st_d  = ST_CHECK;
        end
      end
      ST_CHECK: begin
        if (!dec_ok) begin
          skip_d = 1'b1;
          st_d   = ST_DONE;
        end else if (!fits) begin
          sync_d = 1'b1;
          enc_d  = 1'b1;
          st_d   = ST_DONE;
        end else begin
          st_d = ST_ISSUE;
        end
      end
      ST_ISSUE: begin
        cond_d = cur ? 3'b010 : 3'b001;
        irq_d  = dma_ie[0];
        toggle = dual;
        out_ld = 1'b1;
        st_d   = ST_DONE;
      end
      default: st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= ST_IDLE;
      fmt_q  <= 3'd0;
      skip_q <= 1'b0;
      sync_q <= 1'b0;
      aerr_q <= 1'b0;
      enc_q  <= 1'b0;
      irq_q  <= 1'b0;
      cond_q <= 3'b000;
    end else begin
      st_q   <= st_d;
      fmt_q  <= fmt_d;
      skip_q <= skip_d;
      sync_q <= sync_d;
      aerr_q <= aerr_d;
      enc_q  <= enc_d;
      irq_q  <= irq_d;
      cond_q <= cond_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bpp_q    <= '0;
      tft16_q  <= 1'b0;
      stride_q <= '0;
      first_q  <= '0;
      end_q    <= '0;
      addr_q   <= '0;
    end else if (out_ld) begin
      bpp_q    <= dec_bpp;
      tft16_q  <= dec_tft16;
      stride_q <= g_stride;
      first_q  <= g_first;
      end_q    <= g_end;
      addr_q   <= g_addr;
    end
  end

  assign hdr_req      = (st_q == ST_HDR);
  assign hdr_addr     = sel_top;
  assign done         = (st_q == ST_DONE);
  assign skip         = skip_q;
  assign sync_err     = sync_q;
  assign addr_err     = aerr_q;
  assign en_clear     = enc_q;
  assign dma_cond_set = cond_q;
  assign dma_irq      = irq_q;
  assign cur_frame    = cur;
  assign bpp          = bpp_q;
  assign tft16        = tft16_q;
  assign stride       = stride_q;
  assign line_first   = first_q;
  assign line_end     = end_q;
  assign line_addr    = addr_q;

  assert_strobe_in_done_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (skip || sync_err || addr_err || en_clear || dma_irq || (|dma_cond_set)) |-> done);
  assert_done_single_R11: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
  assert_overflow_stops_R4: assert property (@(posedge clk) disable iff (!rst_n)
    sync_err |-> (en_clear && dma_cond_set == 3'b000 && !addr_err));
  assert_addr_fault_R7: assert property (@(posedge clk) disable iff (!rst_n)
    addr_err |-> (en_clear && dma_cond_set == 3'b100 && !sync_err));
  assert_one_buffer_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (|dma_cond_set[1:0]) |-> ($onehot(dma_cond_set) && !en_clear));
  assert_skip_quiet_R10: assert property (@(posedge clk) disable iff (!rst_n)
    skip |-> (dma_cond_set == 3'b000 && !en_clear));
endmodule

// File: tb/frame_setup_seq_tb.sv
`timescale 1ns/1ps
module frame_setup_seq_tb;
  localparam int AW = 32, DIM_W = 11, LINE_W = 10;

  logic clk, rst_n, start, ctrl_en, tft, dual, sp_on, sp_from_top, hdr_vld;
  logic [1:0] pal_mode, dma_ie;
  logic [DIM_W-1:0] width, height;
  logic [LINE_W-1:0] sp_lines;
  logic [AW-1:0] f0_top, f0_bot, f1_top, f1_bot;
  logic [3:0] addr_ok;
  logic [2:0] hdr_fmt;
  logic hdr_req, done, skip, sync_err, addr_err, en_clear, dma_irq, cur_frame, tft16;
  logic [AW-1:0] hdr_addr, line_addr;
  logic [2:0] dma_cond_set;
  logic [4:0] bpp;
  logic [DIM_W+1:0] stride;
  logic [DIM_W-1:0] line_first, line_end;

  int checks = 0, errors = 0;
  bit m_cur = 0;
  bit [2:0] m_fmt = 0;

  frame_setup_seq #(.AW(AW), .DIM_W(DIM_W), .LINE_W(LINE_W)) u_dut (
    .clk(clk), .rst_n(rst_n), .start(start), .ctrl_en(ctrl_en),
    .pal_mode(pal_mode), .tft(tft), .dual(dual), .dma_ie(dma_ie),
    .width(width), .height(height), .sp_on(sp_on), .sp_from_top(sp_from_top),
    .sp_lines(sp_lines), .f0_top(f0_top), .f0_bot(f0_bot), .f1_top(f1_top),
    .f1_bot(f1_bot), .addr_ok(addr_ok), .hdr_req(hdr_req), .hdr_addr(hdr_addr),
    .hdr_vld(hdr_vld), .hdr_fmt(hdr_fmt), .done(done), .skip(skip),
    .sync_err(sync_err), .addr_err(addr_err), .en_clear(en_clear),
    .dma_cond_set(dma_cond_set), .dma_irq(dma_irq), .cur_frame(cur_frame),
    .bpp(bpp), .tft16(tft16), .stride(stride), .line_first(line_first),
    .line_end(line_end), .line_addr(line_addr)
  );

  initial clk = 0;
  always #5 clk = ~clk;

  task automatic chk(string rq, longint act, longint exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual %0d expected %0d", rq, act, exp);
    end
  endtask

  function automatic longint bpp_of(bit [2:0] f);
    case (f)
      3'd0: return 0;
      3'd1: return 2;
      3'd2: return 4;
      3'd3: return 8;
      default: return 16;
    endcase
  endfunction

  function automatic longint off_of(bit [2:0] f, bit [1:0] pm);
    if (pm == 2) return 0;
    return (f >= 3) ? 512 : 32;
  endfunction

  function automatic longint need_of(bit [2:0] f, bit [1:0] pm, longint w, longint h);
    return off_of(f, pm) + (w * h * bpp_of(f)) / 8;
  endfunction

  task automatic run_frame();
    bit e_noop, e_hdr, e_aerr, e_skip, e_sync, e_enc, e_irq, e_succ, saw_hdr;
    bit [2:0] e_cond, f;
    longint top, bot, req, e_stride, e_first, e_end, e_addr, e_hdr_addr, seen_addr;
    int n;
    e_hdr = 0; e_aerr = 0; e_skip = 0; e_sync = 0; e_enc = 0; e_irq = 0;
    e_succ = 0; e_cond = 0; saw_hdr = 0; seen_addr = 0;
    e_stride = 0; e_first = 0; e_end = 0; e_addr = 0;
    if (!ctrl_en) m_cur = 0;
    e_noop = !ctrl_en || pal_mode == 2'd1;
    top = m_cur ? f1_top : f0_top;
    bot = m_cur ? f1_bot : f0_bot;
    e_hdr_addr = top;
    if (!e_noop) begin
      if (!(addr_ok[0] && addr_ok[1] && (!dual || (addr_ok[2] && addr_ok[3])))) begin
        e_aerr = 1; e_enc = 1; e_cond = 3'b100; e_irq = dma_ie[1];
      end else begin
        if (pal_mode != 2'd2) begin e_hdr = 1; m_fmt = hdr_fmt; end
        f = m_fmt;
        if (f == 0) e_skip = 1;
        else begin
          req = need_of(f, pal_mode, width, height);
          if (req + top > bot + 2) begin e_sync = 1; e_enc = 1; end
          else begin
            e_succ = 1;
            e_cond = m_cur ? 3'b010 : 3'b001;
            e_irq = dma_ie[0];
            e_stride = (longint'(width) * bpp_of(f)) / 8;
            e_first = 0; e_end = height;
            if (sp_on) begin
              if (sp_from_top) e_first = sp_lines; else e_end = sp_lines;
            end
            e_addr = (top + off_of(f, pal_mode) + e_stride * e_first) & 64'hFFFF_FFFF;
            if (dual) m_cur = ~m_cur;
          end
        end
      end
    end
    @(negedge clk) start = 1;
    @(negedge clk) start = 0;
    n = 0;
    while (!done && n < 50) begin
      if (hdr_req) begin saw_hdr = 1; seen_addr = hdr_addr; hdr_vld = 1; end
      else hdr_vld = 0;
      n++;
      @(negedge clk);
    end
    hdr_vld = 0;
    chk("R11 done reached", done, 1);
    chk("R1 header read", saw_hdr, e_hdr);
    if (e_hdr) chk("R3 header address", seen_addr, e_hdr_addr);
    chk("R7 addr_err", addr_err, e_aerr);
    chk("R10 skip", skip, e_skip);
    chk("R4 sync_err", sync_err, e_sync);
    chk("R4 en_clear", en_clear, e_enc);
    chk("R5 dma_cond_set", dma_cond_set, e_cond);
    chk("R5 dma_irq", dma_irq, e_irq);
    chk("R6 cur_frame", cur_frame, m_cur);
    if (e_succ) begin
      chk("R2 bpp", bpp, bpp_of(m_fmt));
      chk("R2 tft16", tft16, m_fmt[2] & tft);
      chk("R9 stride", stride, e_stride);
      chk("R8 line_first", line_first, e_first);
      chk("R8 line_end", line_end, e_end);
      chk("R9 line_addr", line_addr, e_addr);
    end
    @(negedge clk);
    chk("R11 strobes single", {done, skip, sync_err, addr_err, en_clear, dma_irq, dma_cond_set}, 0);
  endtask

  task automatic set_base();
    ctrl_en = 1; pal_mode = 0; tft = 0; dual = 0; dma_ie = 2'b11;
    width = 16; height = 8; sp_on = 0; sp_from_top = 0; sp_lines = 0;
    f0_top = 32'h1000; f1_top = 32'h8000; addr_ok = 4'hF; hdr_fmt = 3'd3;
    f0_bot = 32'h7000; f1_bot = 32'hF000;
  endtask

  task automatic rand_frame();
    bit [2:0] fe;
    longint r;
    int d;
    width = DIM_W'(1 + $urandom % 48);
    height = DIM_W'(1 + $urandom % 48);
    case ($urandom % 8)
      0: pal_mode = 2'd2;
      1: pal_mode = 2'd1;
      2: pal_mode = 2'd3;
      default: pal_mode = 2'd0;
    endcase
    tft = 1'($urandom); dual = 1'($urandom); dma_ie = 2'($urandom);
    ctrl_en = ($urandom % 10) != 0;
    addr_ok = ($urandom % 6 == 0) ? 4'($urandom) : 4'hF;
    hdr_fmt = 3'($urandom);
    sp_on = 1'($urandom); sp_from_top = 1'($urandom);
    sp_lines = LINE_W'($urandom % 48);
    fe = (pal_mode == 2'd2) ? m_fmt : hdr_fmt;
    r = need_of(fe, pal_mode, width, height);
    f0_top = {10'd0, 20'($urandom), 2'b00};
    f1_top = {10'd0, 20'($urandom), 2'b00};
    d = int'($urandom % 9) - 3;
    f0_bot = 32'(longint'(f0_top) + r - 2 + d);
    d = int'($urandom % 9) - 3;
    f1_bot = 32'(longint'(f1_top) + r - 2 + d);
  endtask

  initial begin
    #2_000_000;
    errors++;
    $display("FAIL watchdog expired");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    start = 0; hdr_vld = 0;
    set_base();
    rst_n = 0;
    repeat (3) @(negedge clk);
    chk("R11 reset done", done, 0);
    chk("R11 reset strobes", {skip, sync_err, addr_err, en_clear, dma_irq, dma_cond_set}, 0);
    chk("R6 reset cur_frame", cur_frame, 0);
    chk("R1 reset hdr_req", hdr_req, 0);
    rst_n = 1;
    @(negedge clk);
    // R1 no-op cases
    ctrl_en = 0; run_frame();
    ctrl_en = 1; pal_mode = 2'd1; run_frame();
    // R2 / R3 / R9 each format value
    pal_mode = 0;
    for (int f = 1; f < 8; f++) begin
      hdr_fmt = 3'(f); tft = f[0]; run_frame();
    end
    // R10 format zero
    hdr_fmt = 0; run_frame();
    // R3 headerless reuses stored format (0 after skip), then a valid one
    pal_mode = 2'd2; run_frame();
    pal_mode = 0; hdr_fmt = 3'd2; run_frame();
    pal_mode = 2'd2; run_frame();
    // R4 boundary: exact fit then one byte short
    pal_mode = 0; hdr_fmt = 3'd3;
    f0_bot = 32'(longint'(f0_top) + need_of(3, 0, width, height) - 2); run_frame();
    f0_bot = 32'(longint'(f0_top) + need_of(3, 0, width, height) - 3); run_frame();
    f0_bot = 32'h7000;
    // R7 buffer 1 flags ignored when single, used when dual
    addr_ok = 4'b0011; run_frame();
    dual = 1; run_frame();
    addr_ok = 4'b1110; dual = 0; dma_ie = 2'b01; run_frame();
    addr_ok = 4'hF; dma_ie = 2'b10;
    // R6 double buffering then disable
    dual = 1; run_frame(); run_frame(); run_frame();
    ctrl_en = 0; @(negedge clk); @(negedge clk);
    chk("R6 cleared while disabled", cur_frame, 0);
    m_cur = 0;
    ctrl_en = 1; dual = 0;
    // R8 subpanel modes
    sp_on = 1; sp_from_top = 1; sp_lines = 5; run_frame();
    sp_from_top = 0; sp_lines = 3; run_frame();
    sp_on = 0; run_frame();
    for (int i = 0; i < 250; i++) begin
      rand_frame();
      run_frame();
    end
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'd1234));
  end
endmodule